// File: doc/BRIEF.md
# Divider Setting Loader for a Clock Synthesizer

This block is the programming front end of a frequency synthesizer. It keeps a 9-bit feedback divide value M and a one-bit output divide select, and reports the current M, the resulting output divide ratio (2 or 4) and whether M falls inside the range the loop can lock to. Two load paths write the same registers. The parallel path takes M from nine pins under an active-low strobe. The serial path shifts a framed bit stream in on a slow serial clock and commits it under a serial load strobe.

Everything runs on one fast system clock. The parallel strobe, the serial load strobe, the serial clock and the serial data pass through a two-flop synchronizer. Edges are found by comparing each synchronized signal with a copy delayed by one more cycle, so an input change reaches the outputs three system clock edges later. A serial frame is 14 slots long: four filler slots, the divide select, then M from its top bit down to bit 0. The register keeps only the last ten bits shifted in, so the filler slots never reach the divider registers.

Top module: `divcfg_loader`

## Requirements
- R1: While reset is high, M loads the value on the parallel pins and the output ratio reads 2.
- R2: While the parallel strobe is low, M follows the parallel pins.
- R3: After the parallel strobe returns high, pin changes leave M unchanged.
- R4: Any parallel load sets the output ratio to 2, even when a serial load had selected 4.
- R5: A serial frame is 14 slots: four ignored slots, then the divide select bit, then M8 down to M0 (M0 last). Only the last ten bits shifted before the commit are used.
- R6: A rising edge on the serial load strobe (parallel strobe high) copies the shift register into M (low nine bits) and the divide select (bit 9).
- R7: Once the serial load strobe has fallen, more serial clock edges leave M and the ratio unchanged.
- R8: While the serial load strobe stays high, each rising serial clock edge writes the newly shifted contents straight into M and the divide select.
- R9: Divide select 0 gives out_div = 3'd2; divide select 1 gives out_div = 3'd4. No other value appears.
- R10: m_lockable is 1 exactly when 125 <= M <= 350.
- R11: Serial clock edges while the parallel strobe is low do not shift, so a frame shifted earlier is still committed by a later serial load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_ld_n | input | 1 | Parallel load strobe, active low |
| m_pins | input | 9 | Parallel M value |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_dat | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial load strobe |
| m_val | output | 9 | Current M value |
| out_div | output | 3 | Output divide ratio, 2 or 4 |
| m_lockable | output | 1 | M lies in the lockable range |

## Verification
The bench uses the default parameters: a 9-bit M, a lock window of 125 to 350 and two synchronizer stages. With these values both window edges (124, 125, 350, 351) and the extremes 0 and 511 can be reached through either load path in one short frame. Because there are only two stages, every result appears a fixed, small number of system cycles after its strobe edge, and a serial clock half period of four system cycles is enough for every edge to be seen.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam logic [2:0] RATIO_LO = 3'd2;
  localparam logic [2:0] RATIO_HI = 3'd4;

  function automatic logic [2:0] ratio_of(input logic sel);
    return sel ? RATIO_HI : RATIO_LO;
  endfunction
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  // STAGES synchronizer flops plus one delayed copy used for edge detection
  logic [W-1:0] chain [STAGES+1];

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
  parameter int SH_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            din,
  output logic [SH_W-1:0] sh_q,
  output logic [SH_W-1:0] sh_nxt
);
  // Older bits fall off the top, so filler slots never survive a full frame
  assign sh_nxt = {sh_q[SH_W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst)           sh_q <= '0;
    else if (shift_en) sh_q <= sh_nxt;
  end
endmodule

// File: rtl/divcfg_regs.sv
module divcfg_regs
  import divcfg_pkg::*;
#(
  parameter int M_W      = 9,
  parameter int LOCK_MIN = 125,
  parameter int LOCK_MAX = 350
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         par_act,
  input  logic [M_W-1:0] m_pins,
  input  logic         ld_copy,
  input  logic         pass,
  input  logic [M_W:0] sh_q,
  input  logic [M_W:0] sh_nxt,
  output logic [M_W-1:0] m_q,
  output logic [2:0]   ratio_q,
  output logic         lock_q
);
  logic [M_W-1:0] m_nxt;
  logic           n_q, n_nxt;

  // Priority: parallel path, serial commit edge, serial pass-through
  always_comb begin
    m_nxt = m_q;
    n_nxt = n_q;
    if (par_act) begin
      m_nxt = m_pins;
      n_nxt = 1'b0;
    end else if (ld_copy) begin
      m_nxt = sh_q[M_W-1:0];
      n_nxt = sh_q[M_W];
    end else if (pass) begin
      m_nxt = sh_nxt[M_W-1:0];
      n_nxt = sh_nxt[M_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q     <= m_pins;
      n_q     <= 1'b0;
      ratio_q <= RATIO_LO;
      lock_q  <= (int'(m_pins) >= LOCK_MIN) && (int'(m_pins) <= LOCK_MAX);
    end else begin
      m_q     <= m_nxt;
      n_q     <= n_nxt;
      ratio_q <= ratio_of(n_nxt);
      lock_q  <= (int'(m_nxt) >= LOCK_MIN) && (int'(m_nxt) <= LOCK_MAX);
    end
  end
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader #(
  parameter int M_W      = 9,
  parameter int STAGES   = 2,
  parameter int LOCK_MIN = 125,
  parameter int LOCK_MAX = 350
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_ld_n,
  input  logic [M_W-1:0] m_pins,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  output logic [M_W-1:0] m_val,
  output logic [2:0]     out_div,
  output logic           m_lockable
);
  localparam int SH_W = M_W + 1;

  // Bit order: {parallel strobe, serial load, serial clock, serial data}
  logic [3:0] s_now, s_prev;
  logic       par_s, ld_s, ld_p, sck_s, sck_p, dat_s;
  logic       unused_dat_prev;
  logic       ld_rise, sck_rise, par_act, ld_copy, pass, shift_en;
  logic [SH_W-1:0] sh_q, sh_nxt;

  divcfg_sync #(.W(4), .STAGES(STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_in   ({par_ld_n, ser_ld, ser_clk, ser_dat}),
    .q      (s_now),
    .q_prev (s_prev)
  );

  assign par_s           = s_now[3];
  assign ld_s            = s_now[2];
  assign ld_p            = s_prev[2];
  assign sck_s           = s_now[1];
  assign sck_p           = s_prev[1];
  assign dat_s           = s_now[0];
  assign unused_dat_prev = s_prev[0] ^ s_prev[3];

  assign ld_rise  = ld_s & ~ld_p;
  assign sck_rise = sck_s & ~sck_p;
  assign par_act  = ~par_s;
  assign shift_en = par_s & sck_rise;
  assign ld_copy  = par_s & ld_rise;
  assign pass     = par_s & ld_s & sck_rise;

  divcfg_shift #(.SH_W(SH_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .din      (dat_s),
    .sh_q     (sh_q),
    .sh_nxt   (sh_nxt)
  );

  divcfg_regs #(.M_W(M_W), .LOCK_MIN(LOCK_MIN), .LOCK_MAX(LOCK_MAX)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .par_act (par_act),
    .m_pins  (m_pins),
    .ld_copy (ld_copy),
    .pass    (pass),
    .sh_q    (sh_q),
    .sh_nxt  (sh_nxt),
    .m_q     (m_val),
    .ratio_q (out_div),
    .lock_q  (m_lockable)
  );
endmodule

// File: rtl/divcfg_loader_chk.sv
module divcfg_loader_chk #(
  parameter int M_W      = 9,
  parameter int LOCK_MIN = 125,
  parameter int LOCK_MAX = 350
) (
  input logic           clk,
  input logic           rst,
  input logic           par_act,
  input logic           ld_copy,
  input logic           pass,
  input logic [M_W:0]   sh_q,
  input logic [M_W:0]   sh_nxt,
  input logic [M_W-1:0] m_pins,
  input logic [M_W-1:0] m_val,
  input logic [2:0]     out_div,
  input logic           m_lockable
);
  p_par_follow_r2: assert property (@(posedge clk) disable iff (rst)
    par_act |=> m_val == $past(m_pins));

  p_par_div2_r4: assert property (@(posedge clk) disable iff (rst)
    par_act |=> out_div == 3'd2);

  p_ser_copy_r6: assert property (@(posedge clk) disable iff (rst)
    (!par_act && ld_copy) |=> m_val == $past(sh_q[M_W-1:0]));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!par_act && !ld_copy && !pass) |=> ($stable(m_val) && $stable(out_div)));

  p_pass_thru_r8: assert property (@(posedge clk) disable iff (rst)
    (!par_act && !ld_copy && pass) |=>
      (m_val == $past(sh_nxt[M_W-1:0]) &&
       out_div == ($past(sh_nxt[M_W]) ? 3'd4 : 3'd2)));

  p_ratio_legal_r9: assert property (@(posedge clk) disable iff (rst)
    (out_div == 3'd2) || (out_div == 3'd4));

  p_lock_window_r10: assert property (@(posedge clk) disable iff (rst)
    m_lockable == ((int'(m_val) >= LOCK_MIN) && (int'(m_val) <= LOCK_MAX)));
endmodule

bind divcfg_loader divcfg_loader_chk #(
  .M_W(M_W), .LOCK_MIN(LOCK_MIN), .LOCK_MAX(LOCK_MAX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .par_act    (par_act),
  .ld_copy    (ld_copy),
  .pass       (pass),
  .sh_q       (sh_q),
  .sh_nxt     (sh_nxt),
  .m_pins     (m_pins),
  .m_val      (m_val),
  .out_div    (out_div),
  .m_lockable (m_lockable)
);

// File: tb/divcfg_loader_test.sv
module divcfg_loader_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_ld_n = 1'b1;
  logic [8:0] m_pins = 9'd200;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       ser_ld = 1'b0;
  logic [8:0] m_val;
  logic [2:0] out_div;
  logic       m_lockable;

  int nchk = 0;
  int nbad = 0;
  int cyc  = 0;
  logic [9:0] sh = '0;

  always #10 clk = ~clk;

  divcfg_loader uut (
    .clk(clk), .rst(rst), .par_ld_n(par_ld_n), .m_pins(m_pins),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
    .m_val(m_val), .out_div(out_div), .m_lockable(m_lockable)
  );

  // {serial?, sel, M, expected ratio, expected lock}
  localparam logic [14:0] VEC [11] = '{
    {1'b0, 1'b0, 9'd124, 3'd2, 1'b0},
    {1'b0, 1'b0, 9'd125, 3'd2, 1'b1},
    {1'b0, 1'b0, 9'd350, 3'd2, 1'b1},
    {1'b0, 1'b0, 9'd351, 3'd2, 1'b0},
    {1'b1, 1'b1, 9'd125, 3'd4, 1'b1},
    {1'b1, 1'b0, 9'd351, 3'd2, 1'b0},
    {1'b1, 1'b1, 9'd350, 3'd4, 1'b1},
    {1'b1, 1'b1, 9'd124, 3'd4, 1'b0},
    {1'b0, 1'b1, 9'd200, 3'd2, 1'b1},
    {1'b1, 1'b0, 9'd0,   3'd2, 1'b0},
    {1'b1, 1'b1, 9'd511, 3'd4, 1'b0}
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic par_load(input logic [8:0] m);
    m_pins = m;
    par_ld_n = 1'b0;
    wait_cyc(6);
    par_ld_n = 1'b1;
    wait_cyc(6);
  endtask

  task automatic shift_bit(input logic b);
    ser_dat = b;
    wait_cyc(4);
    ser_clk = 1'b1;
    wait_cyc(4);
    ser_clk = 1'b0;
    if (par_ld_n) sh = {sh[8:0], b};
  endtask

  // R5: four filler slots, select bit, then M8..M0
  task automatic ser_frame(input logic [3:0] fill, input logic sel, input logic [8:0] m);
    for (int i = 3; i >= 0; i--) shift_bit(fill[i]);
    shift_bit(sel);
    for (int i = 8; i >= 0; i--) shift_bit(m[i]);
    wait_cyc(2);
  endtask

  task automatic ser_commit;
    ser_ld = 1'b1;
    wait_cyc(6);
    ser_ld = 1'b0;
    wait_cyc(6);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    chk("R1 reset M", m_val, 200);
    chk("R1 reset ratio", out_div, 2);
    rst = 1'b0;
    wait_cyc(4);

    // Table walk: R10 window edges, R9 ratio encoding, R4 and R5 paths
    for (int k = 0; k < 11; k++) begin
      if (VEC[k][14]) begin
        ser_frame(4'(k * 5), VEC[k][13], VEC[k][12:4]);
        ser_commit();
      end else begin
        par_load(VEC[k][12:4]);
      end
      chk("R5 R6 M", m_val, int'(VEC[k][12:4]));
      chk("R9 ratio", out_div, int'(VEC[k][3:1]));
      chk("R10 lockable", m_lockable, int'(VEC[k][0]));
    end

    // R2: transparent while strobe low
    par_ld_n = 1'b0;
    m_pins = 9'd300;
    wait_cyc(6);
    chk("R2 follow 300", m_val, 300);
    m_pins = 9'd100;
    wait_cyc(3);
    chk("R2 follow 100", m_val, 100);
    par_ld_n = 1'b1;
    wait_cyc(6);
    // R3: pins ignored after strobe rises
    m_pins = 9'd5;
    wait_cyc(6);
    chk("R3 latched", m_val, 100);

    // R7: held after commit despite more serial clocks
    ser_frame(4'b1111, 1'b1, 9'd250);
    ser_commit();
    chk("R6 commit M", m_val, 250);
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    wait_cyc(4);
    chk("R7 hold M", m_val, 250);
    chk("R7 hold ratio", out_div, 4);

    // R4: parallel forces ratio 2 after serial chose 4
    par_load(9'd130);
    chk("R4 ratio forced", out_div, 2);
    chk("R4 M", m_val, 130);

    // R8: pass-through while serial load held high
    ser_frame(4'b0000, 1'b0, 9'd180);
    ser_ld = 1'b1;
    wait_cyc(6);
    chk("R8 copy on rise", m_val, int'(sh[8:0]));
    for (int i = 0; i < 3; i++) begin
      shift_bit(i[0] ? 1'b0 : 1'b1);
      wait_cyc(1);
      chk("R8 pass M", m_val, int'(sh[8:0]));
      chk("R8 pass ratio", out_div, sh[9] ? 4 : 2);
    end
    ser_ld = 1'b0;
    wait_cyc(6);

    // R11: clocks during parallel mode do not shift
    ser_frame(4'b0101, 1'b0, 9'd180);
    par_ld_n = 1'b0;
    m_pins = 9'd140;
    wait_cyc(6);
    for (int i = 0; i < 10; i++) shift_bit(1'b1);
    chk("R11 parallel value", m_val, 140);
    par_ld_n = 1'b1;
    wait_cyc(6);
    ser_commit();
    chk("R11 earlier frame M", m_val, 180);
    chk("R11 earlier frame ratio", out_div, 2);

    // R1: reset reloads pins
    m_pins = 9'd333;
    rst = 1'b1;
    wait_cyc(3);
    chk("R1 reset reload M", m_val, 333);
    chk("R1 reset reload ratio", out_div, 2);
    rst = 1'b0;
    wait_cyc(2);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule